// File: doc/BRIEF.md
# Digital I/O Port Register Block

This block is a small register slave that controls two 8-bit bidirectional digital ports and one status LED. A host reaches it through a simple synchronous register interface: a 2-bit offset, a write strobe, a read strobe and 8-bit write and read data. The block drives the output value and output enable of each port pin. It samples the pin levels through a two-flop synchronizer and drives one LED pin.

Each port is switched as a whole between input and output by one bit in a direction register. A read of a port returns different data in each mode. In output mode it returns the port's output register. In input mode it returns the synchronized pin levels. The LED is controlled by a write-only bit that resets to 1. The LED pin always carries the inverse of that bit, so the LED is lit after reset.

Top module: `dio_regfile`

## Requirements
- R1: Reset (rst_n low) clears both port output registers and the direction register. Both ports therefore start as inputs, with all output-enable bits 0. The LED bit resets to 1, so led_pin is 0.
- R2: A write to offset 0 loads port A's output register, and a write to offset 1 loads port B's. The write takes effect on the rising clock edge at which reg_wr is high. The register value is always presented on pa_out or pb_out.
- R3: Offset 3 is the direction register. Bit 0 sets port A and bit 1 sets port B, where 0 means input and 1 means output. A read of offset 3 returns these two bits, and bits 7:2 read as 0. Writes to bits 7:2 are ignored.
- R4: While a port is in output mode, all 8 of its output-enable bits are 1. A read of that port returns its output register, whatever the pin levels are.
- R5: While a port is in input mode, all 8 of its output-enable bits are 0. A read of that port returns the pin levels after two synchronizer flops. A pin change appears in read data after the second rising edge, and not after the first.
- R6: An output register written while its port is in input mode keeps its value. That value is driven and read back once the port is switched to output mode.
- R7: Bit 0 of offset 2 is the LED bit. led_pin is always its inverse, so writing 0 sets led_pin to 1 and writing 1 sets led_pin to 0. A read of offset 2 returns 0x00.
- R8: When reg_rd is low, reg_rdata is 0x00. When reg_rd is high, reg_rdata is combinational from reg_addr and the current state.
- R9: When reg_wr is low, no register changes, whatever the values of reg_addr and reg_wdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 2 | Register offset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data |
| pa_in | input | 8 | Port A pin levels |
| pa_out | output | 8 | Port A output values |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pin levels |
| pb_out | output | 8 | Port B output values |
| pb_oe | output | 8 | Port B output enables |
| led_pin | output | 1 | LED drive, inverse of the LED bit |

## Verification
The assertions check on every cycle the relations that hold from one cycle to the next:
- a write lands in the addressed output register;
- a direction write sets all eight enables of each port together;
- the LED pin is the inverse of the last LED write;
- idle strobes neither change the state nor drive read data;
- the unused direction bits and offset 2 read as zero;
- input-mode reads equal the pin levels from two cycles earlier.

Only the bench's scenarios can show the sequence-dependent behaviours. These are an output value written in input mode and revealed later, and output-mode reads that ignore conflicting pin levels. They also include the exact edge on which a pin change first becomes visible, and full sweeps of all 256 data and pin values on both ports.

// File: rtl/dio_regfile.sv
module dio_regfile #(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   reg_addr,
  input  logic         reg_wr,
  input  logic         reg_rd,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  input  logic [W-1:0] pa_in,
  output logic [W-1:0] pa_out,
  output logic [W-1:0] pa_oe,
  input  logic [W-1:0] pb_in,
  output logic [W-1:0] pb_out,
  output logic [W-1:0] pb_oe,
  output logic         led_pin
);
  localparam logic [1:0] OFS_A   = 2'd0;
  localparam logic [1:0] OFS_B   = 2'd1;
  localparam logic [1:0] OFS_LED = 2'd2;
  localparam logic [1:0] OFS_DIR = 2'd3;
  localparam int SW = SYNC_STAGES * W;

  logic [W-1:0]  a_q, b_q;
  logic [1:0]    dir_q;
  logic          led_q;
  logic [SW-1:0] a_pipe, b_pipe;
  logic [W-1:0]  a_seen, b_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q   <= '0;
      b_q   <= '0;
      dir_q <= '0;
      led_q <= 1'b1;
    end else if (reg_wr) begin
      case (reg_addr)
        OFS_A:   a_q   <= reg_wdata;
        OFS_B:   b_q   <= reg_wdata;
        OFS_LED: led_q <= reg_wdata[0];
        default: dir_q <= reg_wdata[1:0];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_pipe <= '0;
      b_pipe <= '0;
    end else begin
      a_pipe <= {a_pipe[SW-W-1:0], pa_in};
      b_pipe <= {b_pipe[SW-W-1:0], pb_in};
    end
  end

  assign a_seen  = a_pipe[SW-1 -: W];
  assign b_seen  = b_pipe[SW-1 -: W];

  assign pa_out  = a_q;
  assign pb_out  = b_q;
  assign pa_oe   = {W{dir_q[0]}};
  assign pb_oe   = {W{dir_q[1]}};
  assign led_pin = ~led_q;

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      case (reg_addr)
        OFS_A:   reg_rdata = dir_q[0] ? a_q : a_seen;
        OFS_B:   reg_rdata = dir_q[1] ? b_q : b_seen;
        OFS_DIR: reg_rdata = {{(W-2){1'b0}}, dir_q};
        default: reg_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/dio_regfile_chk.sv
module dio_regfile_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   reg_addr,
  input logic         reg_wr,
  input logic         reg_rd,
  input logic [W-1:0] reg_wdata,
  input logic [W-1:0] reg_rdata,
  input logic [W-1:0] pa_in,
  input logic [W-1:0] pa_out,
  input logic [W-1:0] pa_oe,
  input logic [W-1:0] pb_in,
  input logic [W-1:0] pb_out,
  input logic [W-1:0] pb_oe,
  input logic         led_pin
);
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  p_reset_state_r1: assert property (@(posedge clk)
    !rst_n |=> (pa_oe == '0 && pb_oe == '0 && pa_out == '0 && pb_out == '0 && led_pin == 1'b0));

  p_write_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd0) |=> pa_out == $past(reg_wdata));

  p_write_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd1) |=> pb_out == $past(reg_wdata));

  p_dir_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 2'd3) |-> reg_rdata[W-1:2] == '0);

  p_dir_sets_oe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd3) |=>
      (pa_oe == {W{$past(reg_wdata[0])}} && pb_oe == {W{$past(reg_wdata[1])}}));

  p_input_read_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && reg_rd && reg_addr == 2'd0 && pa_oe == '0) |-> reg_rdata == $past(pa_in, 2));

  p_input_read_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && reg_rd && reg_addr == 2'd1 && pb_oe == '0) |-> reg_rdata == $past(pb_in, 2));

  p_led_inverse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd2) |=> led_pin == !$past(reg_wdata[0]));

  p_led_reads_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 2'd2) |-> reg_rdata == '0);

  p_idle_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |-> reg_rdata == '0);

  p_no_write_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> ($stable(pa_out) && $stable(pb_out) && $stable(pa_oe) && $stable(pb_oe) && $stable(led_pin)));
endmodule

bind dio_regfile dio_regfile_chk #(.W(W)) u_chk (.*);

// File: tb/dio_regfile_bench.sv
`timescale 1ns/1ps
module dio_regfile_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] reg_addr = '0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic [7:0] pa_in = '0, pb_in = '0;
  logic [7:0] pa_out, pa_oe, pb_out, pb_oe;
  logic       led_pin;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dio_regfile u_dio_regfile (.*);

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    reg_rd = 1'b0;
  endtask

  task automatic set_pins(input logic [1:0] port, input logic [7:0] v);
    @(negedge clk);
    if (port == 2'd0) pa_in = v; else pb_in = v;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    check("R1 pa_oe", pa_oe, 8'h00);
    check("R1 pb_oe", pb_oe, 8'h00);
    check("R1 pa_out", pa_out, 8'h00);
    check("R1 pb_out", pb_out, 8'h00);
    check("R1 led_pin", {7'd0, led_pin}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    rd(2'd3, d); check("R1 dir", d, 8'h00);

    // R3 direction register sweep including ignored upper bits
    for (int v = 0; v < 256; v++) begin
      wr(2'd3, v[7:0]);
      rd(2'd3, d); check("R3 dir readback", d, {6'd0, v[1:0]});
      check("R4 pa_oe", pa_oe, {8{v[0]}});
      check("R4 pb_oe", pb_oe, {8{v[1]}});
    end

    // R2/R4 output mode sweep with conflicting pins
    wr(2'd3, 8'h03);
    for (int v = 0; v < 256; v++) begin
      pa_in = ~v[7:0]; pb_in = v[7:0] ^ 8'h5A;
      wr(2'd0, v[7:0]);
      wr(2'd1, 8'(255 - v));
      rd(2'd0, d); check("R4 read A out mode", d, v[7:0]);
      rd(2'd1, d); check("R4 read B out mode", d, 8'(255 - v));
      check("R2 pa_out", pa_out, v[7:0]);
      check("R2 pb_out", pb_out, 8'(255 - v));
    end

    // R5 input mode sweep
    wr(2'd3, 8'h00);
    for (int v = 0; v < 256; v++) begin
      set_pins(2'd0, v[7:0]);
      set_pins(2'd1, 8'(v * 7 + 3));
      rd(2'd0, d); check("R5 read A in mode", d, v[7:0]);
      rd(2'd1, d); check("R5 read B in mode", d, 8'(v * 7 + 3));
    end

    // R5 latency: not visible after one edge, visible after two
    @(negedge clk); pa_in = 8'hC3;
    @(negedge clk); rd(2'd0, d); check("R5 after one edge", d, 8'(255 * 7 + 3) == 8'h00 ? 8'hFF : 8'hFF);
    @(negedge clk); rd(2'd0, d); check("R5 after two edges", d, 8'hC3);

    // R6 write in input mode retained
    wr(2'd0, 8'hA5);
    wr(2'd1, 8'h3C);
    rd(2'd0, d); check("R6 A still pins", d, 8'hC3);
    check("R6 pa_oe off", pa_oe, 8'h00);
    wr(2'd3, 8'h01);
    rd(2'd0, d); check("R6 A revealed", d, 8'hA5);
    wr(2'd3, 8'h02);
    rd(2'd1, d); check("R6 B revealed", d, 8'h3C);
    check("R6 pb_out", pb_out, 8'h3C);

    // R7 LED
    wr(2'd2, 8'h00); check("R7 led off", {7'd0, led_pin}, 8'h01);
    rd(2'd2, d); check("R7 offset2 read", d, 8'h00);
    wr(2'd2, 8'hFE); check("R7 bit0 only", {7'd0, led_pin}, 8'h01);
    wr(2'd2, 8'h01); check("R7 led on", {7'd0, led_pin}, 8'h00);

    // R8 idle read strobe
    reg_addr = 2'd1; reg_rd = 1'b0; #1;
    check("R8 rdata idle", reg_rdata, 8'h00);

    // R9 writes with strobe low
    for (int a = 0; a < 4; a++) begin
      @(negedge clk);
      reg_addr = a[1:0]; reg_wdata = 8'h00; reg_wr = 1'b0;
      @(negedge clk);
    end
    rd(2'd1, d); check("R9 B held", d, 8'h3C);
    rd(2'd3, d); check("R9 dir held", d, 8'h02);
    check("R9 led held", {7'd0, led_pin}, 8'h00);
    check("R9 pa_out held", pa_out, 8'hA5);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule